// File: doc/BRIEF.md
# Two-Stage Radix-3 Left Shifter

This block moves a data word left by a distance between zero and eight bit positions. Instead of the usual cascade of four binary-weighted 2-to-1 multiplexer columns, it uses only two columns of 3-to-1 multiplexers. The first column moves the word by 0, 1 or 2 places and the second by 0, 3 or 6 places. The 4-bit binary distance is split into two base-3 digits before the multiplexers see it. Positions left empty at the low end are filled with zeros, and bits pushed past the top are lost.

Every input is captured in a register. A register follows each multiplexer column, and the last of these drives the outputs. A request is a data word and a distance, qualified by a valid strobe. Its result appears three clock edges after the request is presented, and one request can be accepted on every cycle. A distance above eight is not a legal request. It still produces a valid output, but that output is all zeros, and a sticky error flag is raised that only reset clears.

Top module: `trit_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `out_data` and `shift_err` are all zero until the first request reaches the output.
- R2: For a legal distance `in_amt` in 0..8, the result is `in_data` shifted left by `in_amt`. Bit i of the result is `in_data[i - in_amt]` when i >= `in_amt` and 0 otherwise, and bits that move above bit 15 are dropped.
- R3: The distance is split into a low digit `in_amt mod 3` (a move of 0, 1 or 2) and a high digit `in_amt div 3` (a move of 0, 3 or 6). These digits drive the first and second columns in that order, each as a 2-bit select with values 0, 1 and 2.
- R4: A request presented with `in_valid` high before clock edge n appears on the output with `out_valid` high right after edge n+2, which is the third edge to sample it.
- R5: Requests on consecutive cycles produce results on consecutive cycles, in the order they were presented.
- R6: A request whose distance is in 9..15 produces a result with `out_valid` high and `out_data` all zeros.
- R7: `shift_err` goes high on the edge where the result of an illegal request appears. It then stays high through any later traffic until reset.
- R8: On a cycle with `in_valid` low, the result three edges later has `out_valid` low, and `out_data` keeps the last result.
- R9: Distance 0 passes the word through unchanged. Distance 8 keeps only the low byte of the input, moved into the high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | 16 | Word to shift |
| in_amt | input | 4 | Unsigned shift distance; 9..15 illegal |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Shifted word, or zero for an illegal distance |
| shift_err | output | 1 | Sticky flag for an illegal distance seen |

## Verification
The case hardest to reach is a result that needs both columns at their largest moves, with data bits crossing the top edge. An example is distance 8 on words with set bits above bit 7. A related case is a distance whose low digit is zero but whose high digit is not, such as 3 or 6. A walking-one sweep crosses every bit position with every distance, back to back, so each multiplexer input of both columns carries a one at some point. Random words with random gaps in the valid strobe then test the hold behaviour. Illegal distances come last, followed by a reset, so that the error flag can be seen both staying high and clearing.

// File: rtl/trit_shift_pkg.sv
package trit_shift_pkg;

   // Select code for one 3-to-1 column: keep, move by one weight, move by two.
   typedef enum logic [1:0] {
      TRIT_0 = 2'd0,
      TRIT_1 = 2'd1,
      TRIT_2 = 2'd2
   } trit_e;

   function automatic int pow3(input int n);
      int r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 3;
      return r;
   endfunction

endpackage

// File: rtl/trit_decode.sv
module trit_decode #(
   parameter int AMT_W      = 4,
   parameter int NUM_DIGITS = 2
) (
   input  logic [AMT_W-1:0]        amt,
   output logic [2*NUM_DIGITS-1:0] sel_vec,
   output logic                    illegal
);
   localparam int MAX_SHIFT = trit_shift_pkg::pow3(NUM_DIGITS) - 1;

   // Binary to base-3, least significant digit in the lowest select slot.
   always_comb begin
      int rem;
      rem = int'(amt);
      for (int k = 0; k < NUM_DIGITS; k++) begin
         sel_vec[2*k +: 2] = 2'(rem % 3);
         rem = rem / 3;
      end
      illegal = (int'(amt) > MAX_SHIFT);
   end

endmodule

// File: rtl/trit_mux_stage.sv
module trit_mux_stage #(
   parameter int WIDTH  = 16,
   parameter int WEIGHT = 1
) (
   input  logic [WIDTH-1:0] din,
   input  logic [1:0]       sel,
   output logic [WIDTH-1:0] dout
);
   import trit_shift_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic src1, src2;
      if (i >= WEIGHT) begin : g_s1
         assign src1 = din[i-WEIGHT];
      end else begin : g_z1
         assign src1 = 1'b0;
      end
      if (i >= 2*WEIGHT) begin : g_s2
         assign src2 = din[i-2*WEIGHT];
      end else begin : g_z2
         assign src2 = 1'b0;
      end
      assign dout[i] = (sel == TRIT_2) ? src2 :
                       (sel == TRIT_1) ? src1 :
                       (sel == TRIT_0) ? din[i] : 1'b0;
   end

endmodule

// File: rtl/trit_shifter.sv
module trit_shifter #(
   parameter int WIDTH      = 16,
   parameter int NUM_DIGITS = 2,
   parameter int AMT_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] in_data,
   input  logic [AMT_W-1:0] in_amt,
   output logic             out_valid,
   output logic [WIDTH-1:0] out_data,
   output logic             shift_err
);
   localparam int MAX_SHIFT = trit_shift_pkg::pow3(NUM_DIGITS) - 1;
   localparam int SEL_W     = 2 * NUM_DIGITS;
   localparam int N         = NUM_DIGITS;

   if (NUM_DIGITS < 1) begin : g_bad_digits
      $error("trit_shifter: NUM_DIGITS must be at least 1");
   end
   if (MAX_SHIFT >= WIDTH) begin : g_bad_width
      $error("trit_shifter: WIDTH must exceed the largest shift");
   end
   if ((1 << AMT_W) <= MAX_SHIFT) begin : g_bad_amt
      $error("trit_shifter: AMT_W too narrow for the shift range");
   end

   // Pipeline: slot 0 is the input register, slot k+1 follows column k.
   logic [(N+1)*WIDTH-1:0] pd;
   logic [N:0]             pv;
   logic [N*SEL_W-1:0]     ps;
   logic [N-1:0]           pill;
   logic [N*WIDTH-1:0]     sd;
   logic [SEL_W-1:0]       dec_sel;
   logic                   dec_ill;
   logic                   err_q;

   trit_decode #(.AMT_W(AMT_W), .NUM_DIGITS(NUM_DIGITS)) u_decode (
      .amt     (in_amt),
      .sel_vec (dec_sel),
      .illegal (dec_ill)
   );

   for (genvar k = 0; k < N; k++) begin : g_col
      trit_mux_stage #(.WIDTH(WIDTH), .WEIGHT(trit_shift_pkg::pow3(k))) u_col (
         .din  (pd[k*WIDTH +: WIDTH]),
         .sel  (ps[k*SEL_W +: 2]),
         .dout (sd[k*WIDTH +: WIDTH])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd    <= '0;
         pv    <= '0;
         ps    <= '0;
         pill  <= '0;
         err_q <= 1'b0;
      end else begin
         pv[0] <= in_valid;
         if (in_valid) begin
            pd[0 +: WIDTH] <= in_data;
            ps[0 +: SEL_W] <= dec_sel;
            pill[0]        <= dec_ill;
         end
         for (int k = 0; k < N; k++) begin
            pv[k+1] <= pv[k];
            if (pv[k]) begin
               if (k == N-1) begin
                  pd[(k+1)*WIDTH +: WIDTH] <= pill[k] ? '0 : sd[k*WIDTH +: WIDTH];
               end else begin
                  pd[(k+1)*WIDTH +: WIDTH] <= sd[k*WIDTH +: WIDTH];
                  ps[(k+1)*SEL_W +: SEL_W] <= ps[k*SEL_W +: SEL_W] >> 2;
                  pill[k+1]                <= pill[k];
               end
            end
         end
         if (pv[N-1] && pill[N-1]) err_q <= 1'b1;
      end
   end

   assign out_valid = pv[N];
   assign out_data  = pd[N*WIDTH +: WIDTH];
   assign shift_err = err_q;

   function automatic int trit_sum(input logic [SEL_W-1:0] v);
      int s, w;
      s = 0;
      w = 1;
      for (int k = 0; k < NUM_DIGITS; k++) begin
         s = s + int'(v[2*k +: 2]) * w;
         w = w * 3;
      end
      return s;
   endfunction

   // R3
   decode_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pv[0] && !pill[0]) |-> (trit_sum(ps[0 +: SEL_W]) == int'($past(in_amt))));

   if (N > 1) begin : g_consumed
      // R3
      digits_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pv[N-1] && !pill[N-1]) |-> (ps[(N-1)*SEL_W+2 +: SEL_W-2] == '0));
   end

   for (genvar k = 0; k < N; k++) begin : g_adv
      // R4
      vld_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pv[k] |=> pv[k+1]);
   end

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R6
   err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (out_valid && out_data == '0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pv[N-1] |=> $stable(out_data));

endmodule

// File: tb/trit_shifter_bench.sv
module trit_shifter_bench;
   localparam int W  = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_data = '0;
   logic [AW-1:0] in_amt = '0;
   logic          out_valid;
   logic [W-1:0]  out_data;
   logic          shift_err;

   int vectors = 0;
   int fails   = 0;

   bit         qv[$];
   logic [W-1:0] qd[$];
   int         qa[$];
   logic [W-1:0] m_data = '0;
   bit         m_err = 1'b0;

   always #10 clk = ~clk;

   trit_shifter u_trit_shifter (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_amt(in_amt), .out_valid(out_valid), .out_data(out_data),
      .shift_err(shift_err)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: compare the entry presented three negedges ago, then drive a new one.
   task automatic step(input bit v, input logic [W-1:0] d, input int a);
      logic [W-1:0] e;
      @(negedge clk);
      if (qv.size() == 3) begin
         bit ev;
         logic [W-1:0] ed;
         int ea;
         string tag;
         ev = qv.pop_front(); ed = qd.pop_front(); ea = qa.pop_front();
         if (ev) m_data = ed;
         if (ev && ea > 8) m_err = 1'b1;
         if (!ev)             tag = "R8 idle hold";
         else if (ea > 8)     tag = "R6 illegal zero";
         else if (ea == 0 || ea == 8) tag = "R9 edge distance";
         else                 tag = "R2 shift result";
         check("R4 valid timing", {15'd0, out_valid}, {15'd0, ev});
         check(tag, out_data, m_data);
         check("R7 sticky error", {15'd0, shift_err}, {15'd0, m_err});
      end
      in_valid = v;
      in_data  = d;
      in_amt   = AW'(a);
      e = (a > 8) ? '0 : W'(d << a);
      qv.push_back(v); qd.push_back(e); qa.push_back(a);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      qv.delete(); qd.delete(); qa.delete();
      m_data = '0; m_err = 1'b0;
      repeat (2) @(negedge clk);
      check("R1 reset valid", {15'd0, out_valid}, 16'd0);
      check("R1 reset data", out_data, 16'd0);
      check("R1 reset error", {15'd0, shift_err}, 16'd0);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      do_reset();
      // R1: outputs stay quiet while the pipe fills with idles
      for (int i = 0; i < 3; i++) step(1'b0, 16'hDEAD, 3);
      check("R1 after release", {out_valid, out_data[14:0]}, 16'd0);
      // R2 R3 R5: walking one, every distance, back to back
      for (int a = 0; a <= 8; a++)
         for (int b = 0; b < W; b++) step(1'b1, W'(1) << b, a);
      // R9: boundary words at distances 0 and 8
      step(1'b1, 16'hFFFF, 8);
      step(1'b1, 16'hA5C3, 8);
      step(1'b1, 16'hA5C3, 0);
      step(1'b1, 16'hFFFF, 0);
      // R3: distances with a zero low digit only
      step(1'b1, 16'h1234, 3);
      step(1'b1, 16'h1234, 6);
      // R2 R8: random words and distances with random idle gaps
      for (int i = 0; i < 600; i++)
         step(($urandom % 4) != 0, W'($urandom), int'($urandom % 9));
      // R8: idles carrying illegal distances must not move anything
      for (int i = 0; i < 5; i++) step(1'b0, W'($urandom), 12);
      // R6 R7: each illegal distance, then legal traffic after the flag
      for (int a = 9; a <= 15; a++) step(1'b1, 16'hFFFF, a);
      for (int i = 0; i < 20; i++) step(1'b1, W'($urandom), int'($urandom % 9));
      for (int i = 0; i < 3; i++) step(1'b0, '0, 0);
      // R1 R7: reset clears the flag
      do_reset();
      for (int i = 0; i < 10; i++) step(1'b1, W'($urandom), int'($urandom % 9));
      for (int i = 0; i < 4; i++) step(1'b0, '0, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule